// File: doc/BRIEF.md
# Fixed-Delay Trigger-to-Result Monitor

This block watches a one-bit trigger and a one-bit result. Every cycle in which the trigger is high opens an attempt. The attempt requires the result to be high exactly `DELAY` clock cycles later. Pending attempts are stored as single bits that march through a chain of packed shift registers, so any number of overlapping attempts cost no extra state. When `DELAY` is larger than the segment limit `SEG_MAX`, the chain is split into several vectors. The top bit of each vector feeds bit 0 of the next vector.

An optional step condition, selected by `STEP_EN`, must stay high in the trigger cycle and in every cycle up to the one before the verdict. This works like a consecutive-repetition guard. A disable input clears the whole chain and silences the verdict in any cycle where it is high.

All pins carry one-bit events sampled on every clock. None of them forms a data stream, so there is no valid/ready handshake and no back-pressure. An attempt can never be stalled. Verdicts come out combinationally from the final chain bit in the verdict cycle.

Top module: `dly_chain_monitor`

## Requirements
- R1: A trigger in cycle t whose attempt survives produces `pass_o` high in cycle t+DELAY when `result_i` is high in that cycle.
- R2: A surviving attempt produces `fail_o` high in cycle t+DELAY when `result_i` is low in that cycle. `pass_o` and `fail_o` are never high together.
- R3: A lone trigger produces no verdict in any cycle other than t+DELAY, even when `result_i` is high throughout.
- R4: Triggers in different cycles, including back-to-back cycles, each get an independent verdict in their own cycle.
- R5: The chain is split into ceil(DELAY/SEG_MAX) vectors. All vectors are SEG_MAX bits wide except the last, which is DELAY - SEG_MAX*(count-1) bits wide. Attempts cross every vector boundary without loss or an extra cycle of delay. This includes a final vector only one bit wide.
- R6: With STEP_EN=1, if `step_ok_i` is low in any cycle from t to t+DELAY-1, the attempt from cycle t is discarded and produces no verdict.
- R7: With STEP_EN=0, `step_ok_i` has no effect on any verdict.
- R8: `disable_i` high in any cycle from t to t+DELAY-1 discards the attempt from cycle t. `disable_i` high in cycle t+DELAY suppresses both verdicts. A trigger arriving while `disable_i` is high is dropped.
- R9: Synchronous reset `rst` (active high) clears every pending attempt. Both outputs are low once reset is released, until a new trigger is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Starts an attempt in this cycle |
| result_i | input | 1 | Outcome sampled in the verdict cycle |
| step_ok_i | input | 1 | Per-step guard (used only when STEP_EN=1) |
| disable_i | input | 1 | Clears all attempts and silences verdicts |
| pass_o | output | 1 | An attempt matured with result high |
| fail_o | output | 1 | An attempt matured with result low |

## Verification
The bench uses a delay of 130, which spans three vectors, and runs a second instance with a delay of 65, whose last vector is a single bit. A dropped or off-by-one carry at a segment seam would move or lose the verdict, and the bench would see it in the wrong cycle or not at all. Step-guard drops are placed at the entry cycle, at the seam, and at the final shift. Disable pulses are placed at the entry cycle, mid-chain, at the last shift, and in the verdict cycle. A design that masked only part of a vector, or let disable lose to a new trigger, would leak a verdict. Overlapping triggers and a reset in the middle of the chain check that attempts neither merge nor survive reset.

// File: rtl/dly_mon_pkg.sv
package dly_mon_pkg;

  // Number of packed vectors needed for a chain of `depth` stages.
  function automatic int seg_count(input int depth, input int seg_max);
    return (depth + seg_max - 1) / seg_max;
  endfunction

  // Width of vector `idx`: full vectors first, remainder last.
  function automatic int seg_width(input int depth, input int seg_max, input int idx);
    int n;
    n = seg_count(depth, seg_max);
    if (idx < n - 1) return seg_max;
    return depth - seg_max * (n - 1);
  endfunction

endpackage

// File: rtl/dly_seg.sv
module dly_seg #(
  parameter int W = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic adv_i,
  input  logic cin_i,
  output logic top_o
);

  logic [W-1:0] q;

  if (W == 1) begin : g_single
    always_ff @(posedge clk) begin
      if (rst || clr_i) q <= '0;
      else              q <= cin_i & adv_i;
    end
  end else begin : g_multi
    always_ff @(posedge clk) begin
      if (rst || clr_i) q <= '0;
      else              q <= {q[W-2:0], cin_i} & {W{adv_i}};
    end

    AST_SEG_SHIFT: assert property (@(posedge clk) disable iff (rst)
      (!clr_i && adv_i) |=> (q[W-1:1] == $past(q[W-2:0]))); // R1
  end

  assign top_o = q[W-1];

  AST_SEG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (q == '0)); // R8
  AST_SEG_KILL: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !adv_i) |=> (q == '0)); // R6
  AST_SEG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && adv_i && cin_i) |=> q[0]); // R5

endmodule

// File: rtl/dly_verdict.sv
module dly_verdict (
  input  logic clk,
  input  logic rst,
  input  logic due_i,
  input  logic result_i,
  input  logic quiet_i,
  output logic pass_o,
  output logic fail_o
);

  always_comb begin
    pass_o = due_i &&  result_i && !quiet_i;
    fail_o = due_i && !result_i && !quiet_i;
  end

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pass_o && fail_o)); // R2
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    quiet_i |-> (!pass_o && !fail_o)); // R8

endmodule

// File: rtl/dly_chain_monitor.sv
module dly_chain_monitor #(
  parameter int DELAY   = 130,
  parameter int SEG_MAX = 64,
  parameter bit STEP_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  input  logic result_i,
  input  logic step_ok_i,
  input  logic disable_i,
  output logic pass_o,
  output logic fail_o
);

  localparam int NSEG = dly_mon_pkg::seg_count(DELAY, SEG_MAX);

  logic            adv;
  logic [NSEG-1:0] seg_top;

  if (STEP_EN) begin : g_step
    assign adv = step_ok_i;
  end else begin : g_nostep
    assign adv = 1'b1;
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam int W = dly_mon_pkg::seg_width(DELAY, SEG_MAX, g);
    logic cin;
    logic top;
    if (g == 0) begin : g_head
      assign cin = trig_i;
    end else begin : g_link
      assign cin = seg_top[g-1];
    end
    dly_seg #(.W(W)) u_seg (
      .clk   (clk),
      .rst   (rst),
      .clr_i (disable_i),
      .adv_i (adv),
      .cin_i (cin),
      .top_o (top)
    );
    assign seg_top[g] = top;
  end

  dly_verdict u_verdict (
    .clk      (clk),
    .rst      (rst),
    .due_i    (seg_top[NSEG-1]),
    .result_i (result_i),
    .quiet_i  (disable_i),
    .pass_o   (pass_o),
    .fail_o   (fail_o)
  );

endmodule

// File: tb/dly_chain_monitor_tb_top.sv
module dly_chain_monitor_tb_top;

  localparam int D1 = 130;
  localparam int D2 = 65;
  localparam int NCASE = 9;
  // columns: result level, step-drop cycle, disable cycle (-1 = none)
  localparam int CASES [NCASE][3] = '{
    '{1, -1, -1}, '{0, -1, -1}, '{1, 0, -1}, '{1, 64, -1}, '{0, 129, -1},
    '{0, -1, 63}, '{0, -1, 130}, '{1, -1, 129}, '{0, -1, 0}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0, trig2 = 1'b0, res = 1'b0, stp = 1'b1, dis = 1'b0;
  logic pass1, fail1, pass2, fail2;
  int checks = 0, errors = 0;
  int p_n, f_n, p_first, p_last, f_at, p2_n, f2_n, p2_at, f2_at;

  always #4 clk = ~clk;

  dly_chain_monitor #(.DELAY(D1), .SEG_MAX(64), .STEP_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .trig_i(trig), .result_i(res), .step_ok_i(stp),
    .disable_i(dis), .pass_o(pass1), .fail_o(fail1));

  dly_chain_monitor #(.DELAY(D2), .SEG_MAX(64), .STEP_EN(1'b0)) dut_plain_i (
    .clk(clk), .rst(rst), .trig_i(trig2), .result_i(res), .step_ok_i(stp),
    .disable_i(dis), .pass_o(pass2), .fail_o(fail2));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    p_n = 0; f_n = 0; p_first = -1; p_last = -1; f_at = -1;
    p2_n = 0; f2_n = 0; p2_at = -1; f2_at = -1;
  endtask

  task automatic cyc(input int k, input logic t, input logic t2, input logic r,
                     input logic s, input logic d, input logic rs);
    @(negedge clk);
    trig = t; trig2 = t2; res = r; stp = s; dis = d; rst = rs;
    #2;
    if (pass1) begin p_n++; if (p_first < 0) p_first = k; p_last = k; end
    if (fail1) begin f_n++; f_at = k; end
    if (pass2) begin p2_n++; p2_at = k; end
    if (fail2) begin f2_n++; f2_at = k; end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", checks, errors);
    $finish;
  end

  initial begin
    clear_log();
    for (int k = 0; k < 4; k++) cyc(k, 0, 0, 0, 1, 0, 1);
    cyc(0, 0, 0, 1, 1, 0, 0);
    chk("R9 reset pass", p_n + p2_n, 0);
    chk("R9 reset fail", f_n + f2_n, 0);

    // table walk: R1 R2 R3 R5 R6 R8
    for (int c = 0; c < NCASE; c++) begin
      int r, dr, dd, ok, ep, ef;
      r = CASES[c][0]; dr = CASES[c][1]; dd = CASES[c][2];
      ok = !(dr >= 0 && dr <= D1 - 1) && !(dd >= 0 && dd <= D1);
      ep = (ok && r == 1) ? 1 : 0;
      ef = (ok && r == 0) ? 1 : 0;
      clear_log();
      for (int k = 0; k < D1 + 3; k++)
        cyc(k, k == 0, 0, r[0], k != dr, k == dd, 0);
      chk($sformatf("R1/R6/R8 case%0d pass count", c), p_n, ep);
      chk($sformatf("R2/R6/R8 case%0d fail count", c), f_n, ef);
      if (ep == 1) chk($sformatf("R3 R5 case%0d pass cycle", c), p_last, D1);
      if (ef == 1) chk($sformatf("R3 R5 case%0d fail cycle", c), f_at, D1);
    end

    // R4: overlapping triggers at 0, 1, 5
    clear_log();
    for (int k = 0; k < D1 + 8; k++)
      cyc(k, (k == 0) || (k == 1) || (k == 5), 0, (k == D1) || (k == D1 + 5), 1, 0, 0);
    chk("R4 overlap pass count", p_n, 2);
    chk("R4 overlap first pass", p_first, D1);
    chk("R4 overlap last pass", p_last, D1 + 5);
    chk("R4 overlap fail count", f_n, 1);
    chk("R4 overlap fail cycle", f_at, D1 + 1);

    // R9: reset mid-chain
    clear_log();
    for (int k = 0; k < D1 + 5; k++)
      cyc(k, k == 0, k == 0, 0, 1, 0, k == 50);
    chk("R9 midflight reset pass", p_n + p2_n, 0);
    chk("R9 midflight reset fail", f_n + f2_n, 0);

    // R7 R5: plain instance, one-bit tail vector, guard held low
    clear_log();
    for (int k = 0; k < D2 + 3; k++) cyc(k, 0, k == 0, 1, 0, 0, 0);
    chk("R7 guard ignored pass count", p2_n, 1);
    chk("R5 one-bit tail pass cycle", p2_at, D2);
    chk("R3 guarded instance quiet", p_n + f_n, 0);
    clear_log();
    for (int k = 0; k < D2 + 3; k++) cyc(k, 0, k == 0, 0, 0, 0, 0);
    chk("R2 plain fail count", f2_n, 1);
    chk("R2 plain fail cycle", f2_at, D2);
    chk("R2 plain no pass", p2_n, 0);

    $display("  [TB] %0d tests run, %0d failed", checks, errors);
    $finish;
  end

endmodule